// File: doc/BRIEF.md
# Loopback BIST Pattern Checker

This block judges the words that come back on a data-loopback self-test. Each received 32-bit word that arrives with its valid strobe, while the test is enabled, is compared with an expected word. The expected word is either a programmable fixed pattern, repeated for every word, or the output of an internal 32-bit LFSR. A select bit picks between the two.

The block keeps a sticky pass flag and a saturating 12-bit mismatch counter. Dropping the enable bit re-arms the test: the flag returns to 1, the counter to zero, and the LFSR to its seed. Both the pattern and a packed status word can be read through a simple combinational read port. The pattern is written through a one-cycle write strobe.

Top module: `lb_pattern_checker`

## Requirements
- R1: After reset, the pattern reads 0x0000_0000 and the status word reads 0x8000_0000.
- R2: A cycle with `pat_wr_i` high loads `pat_wdata_i` into the pattern. It reads back with `rd_sel_i`=0 from the next cycle on. A comparison in the write cycle still uses the old pattern.
- R3: With `rd_sel_i`=1 the read port returns the status word: bit 31 is the pass flag, bits 30:12 are 0 and bits 11:0 are the mismatch count.
- R4: With `pat_sel_i`=1, every compared word is checked against the stored pattern.
- R5: With `pat_sel_i`=0, the expected word is the LFSR state. The seed is 0xACE1_2345. Each compared word advances the state as next = (s >> 1) ^ (s[0] ? 0x8020_0003 : 0). This happens in both modes.
- R6: A mismatching comparison increments the count and clears the pass flag. Both changes are visible in the cycle after the compare. The flag stays 0 while enable stays 1.
- R7: The count saturates at 0xFFF. Further mismatches leave it at 0xFFF.
- R8: In any cycle with `enable_i`=0, the flag is set to 1, the count is cleared and the LFSR is reloaded with its seed. The result is visible in the next cycle.
- R9: A cycle with `rx_valid_i`=0 makes no comparison and does not advance the LFSR. The same holds for a cycle with `enable_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Test enable; low re-arms flag, counter and LFSR |
| pat_sel_i | input | 1 | 1: fixed pattern, 0: LFSR |
| pat_wr_i | input | 1 | Pattern write strobe |
| pat_wdata_i | input | 32 | Pattern write data |
| rx_valid_i | input | 1 | Received word valid |
| rx_data_i | input | 32 | Received word |
| rd_sel_i | input | 1 | Read select: 0 pattern, 1 status |
| rd_data_o | output | 32 | Read data (combinational) |

## Verification
Every comparison and every enable-low cycle acts at the clock edge that samples it. Its effect on the status word is due one cycle later, and the read port reflects it without further delay. The bench drives inputs on the falling edge and applies the same update to its reference model at the rising edge. It then reads and compares the status word at the following falling edge, so each check sees exactly the edge it predicts. Pattern writes follow the same one-edge rule. A comparison made in the write cycle is modelled against the old pattern.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 12;
  localparam logic [DATA_W-1:0] LFSR_SEED = 32'hACE1_2345;
  localparam logic [DATA_W-1:0] LFSR_MASK = 32'h8020_0003;
  typedef enum logic {RD_PATTERN = 1'b0, RD_STATUS = 1'b1} rd_sel_e;
endpackage

// File: rtl/lbk_lfsr.sv
module lbk_lfsr #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reload_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (reload_i)    state_d = SEED;
    else if (step_i) state_d = (state_q >> 1) ^ (state_q[0] ? MASK : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lbk_err_track.sv
module lbk_err_track #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rearm_i,
  input  logic             miss_i,
  output logic             good_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic             good_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= 1'b1;
      cnt_q  <= '0;
    end else if (rearm_i) begin
      good_q <= 1'b1;
      cnt_q  <= '0;
    end else if (miss_i) begin
      good_q <= 1'b0;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign good_o = good_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/lb_pattern_checker.sv
module lb_pattern_checker
  import lbk_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned CW     = CNT_W,
  parameter logic [W-1:0] SEED  = LFSR_SEED,
  parameter logic [W-1:0] MASK  = LFSR_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         pat_sel_i,
  input  logic         pat_wr_i,
  input  logic [W-1:0] pat_wdata_i,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i,
  input  logic         rd_sel_i,
  output logic [W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = W - 1 - CW;

  logic [W-1:0]  pattern_q;
  logic [W-1:0]  lfsr_word;
  logic [W-1:0]  expect_word;
  logic          cmp_en;
  logic          miss;
  logic          good_flag;
  logic [CW-1:0] err_cnt;
  logic [W-1:0]  status_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pattern_q <= '0;
    else if (pat_wr_i) pattern_q <= pat_wdata_i;
  end

  assign cmp_en      = enable_i & rx_valid_i;
  assign expect_word = pat_sel_i ? pattern_q : lfsr_word;
  assign miss        = cmp_en & (rx_data_i != expect_word);

  lbk_lfsr #(.W(W), .SEED(SEED), .MASK(MASK)) u_lfsr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (!enable_i),
    .step_i   (cmp_en),
    .state_o  (lfsr_word)
  );

  lbk_err_track #(.CNT_W(CW)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rearm_i (!enable_i),
    .miss_i  (miss),
    .good_o  (good_flag),
    .cnt_o   (err_cnt)
  );

  assign status_word = {good_flag, {PAD_W{1'b0}}, err_cnt};
  assign rd_data_o   = (rd_sel_i == RD_STATUS) ? status_word : pattern_q;
endmodule

// File: rtl/lb_pattern_checker_sva.sv
module lb_pattern_checker_sva #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          rx_valid_i,
  input logic          good_q,
  input logic [CW-1:0] cnt_q,
  input logic [W-1:0]  status
);
  localparam logic [CW-1:0] CMAX = '1;

  p_pad_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[W-2:CW] == '0);

  p_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (good_q && cnt_q == '0));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !good_q) |=> !good_q);

  p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && cnt_q == CMAX) |=> cnt_q == CMAX);

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !rx_valid_i) |=> ($stable(cnt_q) && $stable(good_q)));
endmodule

bind lb_pattern_checker lb_pattern_checker_sva #(.W(W), .CW(CW)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .rx_valid_i (rx_valid_i),
  .good_q     (good_flag),
  .cnt_q      (err_cnt),
  .status     (status_word)
);

// File: tb/test_lb_pattern_checker.sv
`timescale 1ns/1ps
module test_lb_pattern_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, sel = 1'b0, wr = 1'b0, vld = 1'b0, rsel = 1'b0;
  logic [31:0] wdata = '0, rxd = '0, rdata;

  int checks = 0, errors = 0;
  logic [31:0] m_pat, m_lfsr;
  logic        m_good;
  logic [11:0] m_cnt;

  always #2.5 clk = ~clk;

  lb_pattern_checker i_lb_pattern_checker (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .pat_sel_i(sel),
    .pat_wr_i(wr), .pat_wdata_i(wdata), .rx_valid_i(vld), .rx_data_i(rxd),
    .rd_sel_i(rsel), .rd_data_o(rdata)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] r = {1'b0, s[31:1]};
    if (s[0]) r = r ^ 32'h8020_0003;
    return r;
  endfunction

  function automatic logic [31:0] m_expect();
    return sel ? m_pat : m_lfsr;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd_status(input string req);
    rsel = 1'b1; #0.1;
    chk(req, rdata, {m_good, 19'd0, m_cnt});
  endtask

  // drive at negedge, model at posedge, sample at next negedge
  task automatic step(input logic e, input logic s, input logic v,
                      input logic [31:0] d, input logic w = 1'b0,
                      input logic [31:0] wd = '0);
    en = e; sel = s; vld = v; rxd = d; wr = w; wdata = wd;
    @(posedge clk);
    if (!e) begin
      m_lfsr = 32'hACE1_2345; m_good = 1'b1; m_cnt = '0;
    end else if (v) begin
      if (d != m_expect()) begin
        m_good = 1'b0;
        if (m_cnt != 12'hFFF) m_cnt++;
      end
      m_lfsr = nxt(m_lfsr);
    end
    if (w) m_pat = wd;
    @(negedge clk);
    wr = 1'b0; vld = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_pat = '0; m_lfsr = 32'hACE1_2345; m_good = 1'b1; m_cnt = '0;
    repeat (3) @(negedge clk);
    rsel = 1'b0; #0.1; chk("R1 pattern", rdata, 32'h0);
    rd_status("R1 status");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: write, then read back; compare in write cycle uses old pattern (0)
    sel = 1'b1;
    step(1, 1, 1, 32'h0, 1, 32'hDEAD_BEEF);
    rsel = 1'b0; #0.1; chk("R2 readback", rdata, 32'hDEAD_BEEF);
    rd_status("R2 old pattern used");

    // R4: fixed pattern match and mismatch
    step(1, 1, 1, 32'hDEAD_BEEF);
    rd_status("R4 match");
    step(1, 1, 1, 32'h1234_5678);
    rd_status("R4 R6 mismatch");
    step(1, 1, 1, 32'hDEAD_BEEF);
    rd_status("R6 sticky");

    // R9: valid low, no effect
    step(1, 1, 0, 32'h0);
    rd_status("R9 valid low");

    // R8: re-arm
    step(0, 1, 1, 32'h0);
    rd_status("R8 rearm");
    step(0, 1, 1, 32'h5);
    rd_status("R9 enable low no compare");

    // R5: LFSR stream from seed, all matching
    for (int i = 0; i < 20; i++) begin
      step(1, 0, 1, m_lfsr);
      if (i % 5 == 4) rd_status("R5 lfsr match");
    end
    step(1, 0, 0, 32'h0);
    step(1, 0, 1, m_lfsr);
    rd_status("R5 R9 no advance on idle");
    step(1, 0, 1, ~m_lfsr);
    rd_status("R5 lfsr mismatch");

    // R7: saturation
    step(0, 1, 0, 0);
    for (int i = 0; i < 4100; i++) step(1, 1, 1, ~m_pat);
    rd_status("R7 saturated");
    chk("R7 count", {20'd0, rdata[11:0]}, 32'hFFF);
    step(1, 1, 1, ~m_pat);
    rd_status("R7 hold");
    chk("R3 layout", rdata, 32'h0000_0FFF);
    step(0, 0, 0, 0);
    rd_status("R8 clear after sat");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic e, s, v, w;
      logic [31:0] d;
      e = ($urandom % 16) != 0;
      s = $urandom % 2;
      v = ($urandom % 4) != 0;
      w = ($urandom % 32) == 0;
      sel = s;
      d = (($urandom % 8) == 0) ? $urandom : m_expect();
      step(e, s, v, d, w, $urandom);
      rd_status("R3 R4 R5 R6 R8 random");
      if (w) begin
        rsel = 1'b0; #0.1; chk("R2 random write", rdata, m_pat);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule